// File: doc/BRIEF.md
# Bidirectional Thermometer Pass-Unit Controller

This block is the digital control loop for a bank of parallel pass-transistor units. It drives one enable line per unit. The lines always form a thermometer code: the units that are on are a contiguous run that starts at unit 0. A comparator input reports whether the regulated output sits below its reference. On each accepted step request the run grows by one unit when the output is low, and shrinks by one unit when the output is high.

The two ends of the run are absorbing stops. A shrink step with every unit off leaves the code as it is. A grow step at the allowed ceiling also leaves the code as it is. The ceiling is the smaller of two values: a runtime limit input, and a build-time count of units given to the digital loop, which by default is one tenth of the bank. Units above that count are never driven.

A freeze input stops all stepping, so the gate lines do not toggle while the load is steady. Dropping the enable input clears the whole bank on the next clock. An output always reports how many units are on. Stepping is event driven: the code moves only on a clock edge that samples the step strobe high.

Top module: `tc_unit_ctl`

## Requirements
- R1: After reset every gate line is 0 and the on-count output is 0.
- R2: On an edge with en=1, step_req=1, freeze=0 and below_ref=1, the code gains exactly one unit, the next higher index, when the on-count is below the ceiling. The ceiling is min(limit, N_DIG).
- R3: On an edge with en=1, step_req=1, freeze=0 and below_ref=0, the highest unit that is on turns off. With every unit off the code stays all zero.
- R4: A grow step at the ceiling leaves the code unchanged. Units with index N_DIG or above are never on, and no unit at index limit or above is turned on by a grow step.
- R5: While freeze=1 (with en=1), step requests leave the code unchanged.
- R6: An edge with step_req=0 (with en=1) leaves the code unchanged.
- R7: An edge with en=0 clears the code to all zero, whatever the other inputs are.
- R8: on_count always equals the number of ones in gate_en. gate_en is always a thermometer pattern: a set bit i implies that every bit below i is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Loop enable; low clears the bank |
| step_req | input | 1 | Step strobe; one step per sampled high |
| below_ref | input | 1 | 1: output under reference (grow), 0: over (shrink) |
| freeze | input | 1 | Holds the code and blocks stepping |
| limit | input | $clog2(N_UNITS+1) | Runtime ceiling on active units |
| gate_en | output | N_UNITS | Thermometer enables for the pass units |
| on_count | output | $clog2(N_UNITS+1) | Number of units on |

## Verification
The main function is tried with three patterns, each repeated for every limit from 0 past N_DIG:
- A run of grow steps longer than the ceiling. This separates correct growth from a failure to stop at the tail or from overshoot of the limit.
- A run of shrink steps longer than the current code. This shows whether the head stop holds at zero or lets the code wrap.
- Alternating grow and shrink steps. This exposes off-by-one errors in the choice of which unit moves.

Frozen steps, idle cycles and enable drops are applied to a partly filled code. Any unintended change therefore shows up directly in the gate lines and in the count.

// File: rtl/tc_pkg.sv
package tc_pkg;
   typedef enum logic [1:0] {
      MV_HOLD  = 2'd0,
      MV_GROW  = 2'd1,
      MV_SHRNK = 2'd2,
      MV_CLEAR = 2'd3
   } move_e;
endpackage

// File: rtl/tc_move_dec.sv
module tc_move_dec
   import tc_pkg::*;
(
   input  logic  en,
   input  logic  step_req,
   input  logic  freeze,
   input  logic  below_ref,
   output move_e move
);
   always_comb begin
      if (!en)                       move = MV_CLEAR;
      else if (freeze || !step_req)  move = MV_HOLD;
      else if (below_ref)            move = MV_GROW;
      else                           move = MV_SHRNK;
   end
endmodule

// File: rtl/tc_cell_chain.sv
module tc_cell_chain
   import tc_pkg::*;
#(
   parameter int N_UNITS = 40,
   parameter int N_DIG   = 4,
   parameter int CW      = $clog2(N_UNITS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  move_e              move,
   input  logic [CW-1:0]      cap,
   output logic [N_UNITS-1:0] gate
);
   genvar i;
   generate
      for (i = 0; i < N_UNITS; i++) begin : g_cell
         if (i < N_DIG) begin : g_live
            logic left_on;
            logic right_on;
            // head reflector: unit 0 always sees an "on" neighbour below
            if (i == 0) begin : g_head
               assign left_on = 1'b1;
            end else begin : g_mid_l
               assign left_on = gate[i-1];
            end
            // tail reflector: the last live unit sees an "off" neighbour above
            if (i == N_DIG - 1) begin : g_tail
               assign right_on = 1'b0;
            end else begin : g_mid_r
               assign right_on = gate[i+1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  gate[i] <= 1'b0;
               end else begin
                  case (move)
                     MV_CLEAR: gate[i] <= 1'b0;
                     MV_GROW:  if (left_on && (CW'(i) < cap)) gate[i] <= 1'b1;
                     MV_SHRNK: if (!right_on) gate[i] <= 1'b0;
                     default:  gate[i] <= gate[i];
                  endcase
               end
            end
         end else begin : g_dead
            assign gate[i] = 1'b0;
         end
      end
   endgenerate

   p_thermo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((gate & (gate + N_UNITS'(1))) == '0));
endmodule

// File: rtl/tc_popcount.sv
module tc_popcount #(
   parameter int N  = 40,
   parameter int CW = $clog2(N + 1)
) (
   input  logic [N-1:0]  vec,
   output logic [CW-1:0] cnt
);
   always_comb begin
      cnt = '0;
      for (int k = 0; k < N; k++) cnt = cnt + CW'(vec[k]);
   end
endmodule

// File: rtl/tc_unit_ctl.sv
module tc_unit_ctl
   import tc_pkg::*;
#(
   parameter int N_UNITS = 40,
   parameter int N_DIG   = N_UNITS / 10,
   localparam int CW     = $clog2(N_UNITS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               step_req,
   input  logic               below_ref,
   input  logic               freeze,
   input  logic [CW-1:0]      limit,
   output logic [N_UNITS-1:0] gate_en,
   output logic [CW-1:0]      on_count
);
   initial begin
      if (N_UNITS < 2)                    $error("N_UNITS must be at least 2");
      if (N_DIG < 1 || N_DIG > N_UNITS)   $error("N_DIG must lie in 1..N_UNITS");
   end

   move_e         move;
   logic [CW-1:0] cap;

   assign cap = (limit < CW'(N_DIG)) ? limit : CW'(N_DIG);

   tc_move_dec u_dec (
      .en(en), .step_req(step_req), .freeze(freeze),
      .below_ref(below_ref), .move(move)
   );

   tc_cell_chain #(.N_UNITS(N_UNITS), .N_DIG(N_DIG), .CW(CW)) u_chain (
      .clk(clk), .rst_n(rst_n), .move(move), .cap(cap), .gate(gate_en)
   );

   tc_popcount #(.N(N_UNITS), .CW(CW)) u_cnt (
      .vec(gate_en), .cnt(on_count)
   );

   p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(on_count) == $countones(gate_en)));
   p_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && step_req && !freeze && below_ref && on_count < cap)
      |=> (on_count == $past(on_count) + CW'(1)));
   p_shrink_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && step_req && !freeze && !below_ref && on_count != '0)
      |=> (on_count == $past(on_count) - CW'(1)));
   p_tail_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && step_req && !freeze && below_ref && on_count >= cap)
      |=> $stable(gate_en));
   p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && freeze) |=> $stable(gate_en));
   p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !step_req) |=> $stable(gate_en));
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en) |=> (gate_en == '0));
endmodule

// File: tb/tc_unit_ctl_tb.sv
module tc_unit_ctl_tb_top;
   localparam int N       = 40;
   localparam int ND      = 4;
   localparam int CW      = $clog2(N + 1);
   localparam int CLK_PER = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, step_req = 1'b0, below_ref = 1'b0, freeze = 1'b0;
   logic [CW-1:0] limit = '0;
   logic [N-1:0]  gate_en;
   logic [CW-1:0] on_count;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int model  = 0;
   int cur_lim = 0;

   always #(CLK_PER/2) clk = ~clk;

   tc_unit_ctl #(.N_UNITS(N), .N_DIG(ND)) dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .step_req(step_req),
      .below_ref(below_ref), .freeze(freeze), .limit(limit),
      .gate_en(gate_en), .on_count(on_count)
   );

   function automatic logic [N-1:0] therm(int k);
      logic [N-1:0] v = '0;
      for (int b = 0; b < N; b++) if (b < k) v[b] = 1'b1;
      return v;
   endfunction

   task automatic check(string req, int exp_cnt);
      checks++;
      if (gate_en !== therm(exp_cnt) || 32'(on_count) != exp_cnt) begin
         fails++;
         $display("FAIL %s gate=%h count=%0d expected gate=%h count=%0d",
                  req, gate_en, on_count, therm(exp_cnt), exp_cnt);
      end
   endtask

   // drive at negedge, let one posedge pass, sample at the next negedge
   task automatic cyc_in(logic e, logic s, logic b, logic f);
      en = e; step_req = s; below_ref = b; freeze = f;
      @(negedge clk);
   endtask

   task automatic grow(string req);
      int cap = (cur_lim < ND) ? cur_lim : ND;
      cyc_in(1'b1, 1'b1, 1'b1, 1'b0);
      if (model < cap) model++;
      check(req, model);
   endtask

   task automatic shrink(string req);
      cyc_in(1'b1, 1'b1, 1'b0, 1'b0);
      if (model > 0) model--;
      check(req, model);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      check("R1 reset", 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 0);

      // sweep every limit past the digital share
      for (int l = 0; l <= ND + 2; l++) begin
         cur_lim = l;
         limit = CW'(l);
         cyc_in(1'b0, 1'b0, 1'b0, 1'b0);
         model = 0;
         check("R7 clear", 0);
         for (int k = 0; k < ND + 3; k++) grow("R2/R4 grow sweep");
         for (int k = 0; k < ND + 3; k++) shrink("R3 shrink sweep");
         for (int k = 0; k < 6; k++) begin
            grow("R2 alternating");
            if (k % 2 == 1) shrink("R3 alternating");
         end
      end

      // partly filled code for the hold checks
      cur_lim = ND;
      limit = CW'(ND);
      cyc_in(1'b0, 1'b0, 1'b0, 1'b0);
      model = 0;
      grow("R2 setup");
      grow("R2 setup");
      cyc_in(1'b1, 1'b1, 1'b1, 1'b1);
      check("R5 frozen grow", model);
      cyc_in(1'b1, 1'b1, 1'b0, 1'b1);
      check("R5 frozen shrink", model);
      cyc_in(1'b1, 1'b0, 1'b1, 1'b0);
      check("R6 idle below", model);
      cyc_in(1'b1, 1'b0, 1'b0, 1'b0);
      check("R6 idle above", model);

      // lowered limit blocks growth but lets shrink proceed
      grow("R2 setup");
      cur_lim = 1;
      limit = CW'(1);
      grow("R4 above lowered limit");
      shrink("R3 under lowered limit");

      // enable drop clears even with a frozen grow request
      cyc_in(1'b0, 1'b1, 1'b1, 1'b1);
      model = 0;
      check("R7 enable low", 0);

      // oversize limit still keeps the dead units off
      cur_lim = N;
      limit = CW'(N);
      for (int k = 0; k < ND + 2; k++) grow("R4 dead units");
      cyc_in(1'b1, 1'b0, 1'b0, 1'b0);

      // reset mid-run returns to all off
      rst_n = 1'b0;
      @(negedge clk);
      model = 0;
      check("R1 async reset", 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule